// File: doc/BRIEF.md
# Half-Bridge Gate Enable Controller with Dead-Time

This block drives the high-side and low-side gate enables of a set of half-bridge output channels. Each channel gets two request bits, held in a serial command register elsewhere: an enable bit and a select bit. Together they pick one of three output states. With the enable low, both switches are off and the output floats. With the enable high, the select bit turns on the low switch (select 0) or the high switch (select 1).

The two switches of one bridge leg must never conduct together. Each channel therefore runs its own small state machine. The machine inserts a programmable dead-time, counted in clock cycles, before it turns on either switch. The delay applies on the way from high to low and on the way from low to high. It also applies when the channel leaves the floating state. Turning a channel off is immediate. If a new request arrives while a dead-time is still counting, the count starts again toward the newest target.

Top module: `hbridge_gate_ctl`

## Requirements
- R1: When a channel's enable bit is 0 at a clock edge, both of its switch enables are 0 after that edge, whatever its select bit holds.
- R2: A channel that holds enable 1 and select 0 long enough settles with the low-side enable at 1 and the high-side enable at 0.
- R3: A channel that holds enable 1 and select 1 long enough settles with the high-side enable at 1 and the low-side enable at 0.
- R4: The high-side and low-side enables of one channel are never 1 in the same cycle.
- R5: When a low-side request (enable 1, select 0) is first sampled and the low side is not already on, both enables stay 0 for exactly LS_GAP cycles, and the low side turns on at the edge after those cycles.
- R6: When a high-side request (enable 1, select 1) is first sampled and the high side is not already on, both enables stay 0 for exactly HS_GAP cycles, and the high side turns on at the edge after those cycles.
- R7: A switch that is on turns off at the first clock edge that samples a request for a different state, with no delay.
- R8: A request that changes while a dead-time is counting restarts the count, using the gap of the newest target.
- R9: While reset (active low, asynchronous) is asserted, every channel has both enables at 0. After reset every channel starts in the floating state.
- R10: Channels are independent. A request on one channel does not change the enables or the timing of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | CHANNELS | Per-channel enable request; 0 floats the output |
| drv_sel | input | CHANNELS | Per-channel select: 0 requests low side, 1 requests high side |
| hs_en | output | CHANNELS | Per-channel high-side switch enable |
| ls_en | output | CHANNELS | Per-channel low-side switch enable |

## Verification
The bench counts the off cycles of each transition exactly. A design that is off by one cycle, or that swaps the two gap values, fails at the cycle where the switch should turn on. It changes the request partway through a dead-time. A design that does not restart the count then turns on the low side, or turns on the high side too early. It drops the enable while the high side is on and toggles the select while the channel is disabled. A design with a delayed turn-off, or one that honours the select bit while disabled, then shows a switch still on. It also drives two channels toward different targets at once and applies reset in the middle of operation. Here a design with shared counters or a synchronous reset shows up, and a monitor checks every cycle for both switches of one channel being on.

// File: rtl/hbridge_gate_ctl.sv
`timescale 1ns/1ps
module hbridge_gate_ctl #(
  parameter int CHANNELS = 4,
  parameter int LS_GAP   = 3,
  parameter int HS_GAP   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] drv_en,
  input  logic [CHANNELS-1:0] drv_sel,
  output logic [CHANNELS-1:0] hs_en,
  output logic [CHANNELS-1:0] ls_en
);
  localparam int GAP_MAX = (LS_GAP > HS_GAP) ? LS_GAP : HS_GAP;
  localparam int CW      = $clog2(GAP_MAX + 1);

  typedef enum logic [2:0] {S_OFF, S_LS, S_HS, S_WLS, S_WHS} leg_t;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_leg
    leg_t          st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= S_OFF;
        cnt <= '0;
      end else if (!drv_en[g]) begin
        st  <= S_OFF;
        cnt <= '0;
      end else if (!drv_sel[g]) begin
        case (st)
          S_LS: ;
          S_WLS:
            if (cnt == CW'(LS_GAP - 1)) st <= S_LS;
            else cnt <= cnt + 1'b1;
          default: begin
            st  <= S_WLS;
            cnt <= '0;
          end
        endcase
      end else begin
        case (st)
          S_HS: ;
          S_WHS:
            if (cnt == CW'(HS_GAP - 1)) st <= S_HS;
            else cnt <= cnt + 1'b1;
          default: begin
            st  <= S_WHS;
            cnt <= '0;
          end
        endcase
      end
    end

    assign hs_en[g] = (st == S_HS);
    assign ls_en[g] = (st == S_LS);
  end
endmodule

// File: rtl/hbridge_gate_ctl_chk.sv
`timescale 1ns/1ps
module hbridge_gate_ctl_chk #(
  parameter int CHANNELS = 4,
  parameter int LS_GAP   = 3,
  parameter int HS_GAP   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CHANNELS-1:0] drv_en,
  input logic [CHANNELS-1:0] drv_sel,
  input logic [CHANNELS-1:0] hs_en,
  input logic [CHANNELS-1:0] ls_en
);
  for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
    int unsigned gap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap <= 0;
      else if (hs_en[g] || ls_en[g]) gap <= 0;
      else if (gap < 32'hFFFF) gap <= gap + 1;
    end

    p_disable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en[g] |=> (!hs_en[g] && !ls_en[g]));
    p_ls_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ls_en[g] |-> $past(drv_en[g] && !drv_sel[g]));
    p_hs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en[g] |-> $past(drv_en[g] && drv_sel[g]));
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en[g] && ls_en[g]));
    p_ls_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en[g]) |-> (gap >= LS_GAP));
    p_hs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en[g]) |-> (gap >= HS_GAP));
    p_drop_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en[g] && !(drv_en[g] && drv_sel[g])) |=> !hs_en[g]);
  end
endmodule

bind hbridge_gate_ctl hbridge_gate_ctl_chk #(
  .CHANNELS(CHANNELS), .LS_GAP(LS_GAP), .HS_GAP(HS_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_sel(drv_sel),
  .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/tb_hbridge_gate_ctl.sv
`timescale 1ns/1ps
module tb_hbridge_gate_ctl;
  localparam int N  = 4;
  localparam int LG = 3;
  localparam int HG = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] drv_en = '0;
  logic [N-1:0] drv_sel = '0;
  logic [N-1:0] hs_en, ls_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  hbridge_gate_ctl #(.CHANNELS(N), .LS_GAP(LG), .HS_GAP(HG)) dut (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_sel(drv_sel),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  always #10 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(string tag, logic [N-1:0] ehs, logic [N-1:0] els);
    checks++;
    if (hs_en !== ehs || ls_en !== els) begin
      errors++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_en, ls_en, ehs, els);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ((hs_en & ls_en) !== '0) begin
        errors++;
        $display("FAIL R4 overlap: hs=%b ls=%b expected no common bit", hs_en, ls_en);
      end
    end
  end

  task automatic t_reset();
    drv_en = '1; drv_sel = 4'b0101;
    rst_n = 0;
    step();
    expect_out("R9 outputs during reset", '0, '0);
    drv_en = '0;
    rst_n = 1;
    step();
    expect_out("R9 idle after reset", '0, '0);
  endtask

  task automatic t_off_to_ls();
    drv_en = 4'b0001; drv_sel = 4'b0000;
    for (int i = 1; i <= LG; i++) begin
      step();
      expect_out("R5 gap before low side", '0, '0);
    end
    step();
    expect_out("R2 low side on", '0, 4'b0001);
    step();
    expect_out("R2 low side holds", '0, 4'b0001);
  endtask

  task automatic t_ls_to_hs();
    drv_sel = 4'b0001;
    step();
    expect_out("R7 low side drops at once", '0, '0);
    for (int i = 2; i <= HG; i++) begin
      step();
      expect_out("R6 gap before high side", '0, '0);
    end
    step();
    expect_out("R3 high side on", 4'b0001, '0);
  endtask

  task automatic t_hs_to_ls();
    drv_sel = 4'b0000;
    for (int i = 1; i <= LG; i++) begin
      step();
      expect_out("R5 gap high to low", '0, '0);
    end
    step();
    expect_out("R2 low side after high", '0, 4'b0001);
  endtask

  task automatic t_disable();
    drv_sel = 4'b0001;
    for (int i = 0; i <= HG; i++) step();
    expect_out("R3 high side before disable", 4'b0001, '0);
    drv_en = 4'b0000;
    step();
    expect_out("R7 disable drops high side at once", '0, '0);
    for (int i = 0; i < 4; i++) begin
      drv_sel = ~drv_sel;
      step();
      expect_out("R1 select ignored while disabled", '0, '0);
    end
  endtask

  task automatic t_restart();
    drv_en = 4'b0001; drv_sel = 4'b0000;
    step();
    step();
    expect_out("R8 counting toward low side", '0, '0);
    drv_sel = 4'b0001;
    for (int i = 1; i <= HG; i++) begin
      step();
      expect_out("R8 restarted gap", '0, '0);
    end
    step();
    expect_out("R8 high side after restart", 4'b0001, '0);
    drv_en = '0;
    step();
  endtask

  task automatic t_indep();
    drv_en = 4'b0110; drv_sel = 4'b0010;
    for (int j = 1; j <= HG + 1; j++) begin
      step();
      expect_out("R10 two channels, two targets",
                 (j >= HG + 1) ? 4'b0010 : 4'b0000,
                 (j >= LG + 1) ? 4'b0100 : 4'b0000);
    end
    drv_en = 4'b0111; drv_sel = 4'b0010;
    step();
    expect_out("R10 new channel leaves others alone", 4'b0010, 4'b0100);
  endtask

  task automatic t_reset_mid();
    rst_n = 0;
    #1;
    expect_out("R9 asynchronous reset mid run", '0, '0);
    drv_en = '0;
    step();
    rst_n = 1;
    step();
    expect_out("R9 floating after mid reset", '0, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_off_to_ls();
    t_ls_to_hs();
    t_hs_to_ls();
    t_disable();
    t_restart();
    t_indep();
    t_reset_mid();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule